// File: doc/BRIEF.md
# Wait-Mode Clock Gating and Wake Controller

This block puts a processor subsystem into a low-power wait state and brings it back out. A one-cycle strobe from the core, issued when it executes its wait instruction, moves the controller into wait. In wait the CPU clock is gated off. The clocks derived from the peripheral clock source are also gated off when a stop bit is set, and keep running when it is clear. The divided clock runs through the peripheral-source path or bypasses it, depending on the clock that feeds it. Clocks with their own source pass through untouched.

Three events end the wait: an asynchronous hardware reset, a non-maskable interrupt, or one of 64 prioritised peripheral requests. A request can wake the block only if its 3-bit level is non-zero. A request whose per-line flag marks its peripheral as clocked from the gated source is ignored while the stop bit is set. The controller also freezes the port and DAC outputs and the CPU clock selection for the length of the wait, and it drives a clock-output pin from a selectable source.

Top module: `lpw_wait_ctrl`

## Requirements
- R1: A `wait_stb` pulse in the running state sets `in_wait` from the next clock edge, and `cpu_clk_o` stops toggling, resting low.
- R2: While waiting, `nmi` high at a clock edge ends the wait at that edge, whatever the stop bit and the interrupt lines hold.
- R3: A request line `i` wakes the block only when `irq_lvl[3*i+2:3*i]` is non-zero. Level 000 never causes a wake.
- R4: Peripheral clocks `pclk_o` (bit 0 f1, bit 1 f8, bit 2 f32, bit 3 ADC) keep toggling in wait while the stop bit is 0. They rest low in wait while the stop bit is 1, and `div_clk_o` behaves the same way when `div_src_main` is 0.
- R5: With the stop bit at 1, a request whose `irq_gsrc` bit is 1 is ignored. The same request with `irq_gsrc` at 0 still wakes the block.
- R6: With `div_src_main` at 1, `div_clk_o` keeps toggling in wait whatever the stop bit holds.
- R7: `cpu_sel_o` holds, for the whole wait and the resume cycle, the value `cpu_sel_req` had at the strobe edge.
- R8: `port_out`, `dac0_out` and `dac1_out` hold, during wait, the input values sampled at the strobe edge.
- R9: `clko_sel` picks the clock-output source: 0 selects `sub_clk` (always toggles), 1 selects f8 and 2 selects f32 (these toggle in wait only while the stop bit is 0, otherwise they rest low), and 3 drives 0.
- R10: `rst_n` low clears `in_wait` at once and without a clock, returns the stop bit to 0 and the held outputs to 0, and produces no resume pulse.
- R11: A wake by NMI or by interrupt raises `resume_o` for exactly one cycle. That cycle follows the wake edge, and `cpu_clk_o` is enabled again in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wait_stb | input | 1 | Wait-instruction strobe from the core |
| nmi | input | 1 | Non-maskable interrupt request |
| irq_req | input | 64 | Peripheral interrupt requests |
| irq_lvl | input | 192 | 3-bit priority level per request, 000 disables |
| irq_gsrc | input | 64 | 1 marks a peripheral clocked from the gated source |
| stop_wr | input | 1 | Write strobe for the stop bit |
| stop_d | input | 1 | Stop bit value to write |
| cpu_sel_req | input | 2 | CPU clock selection requested by the core |
| cpu_sel_o | output | 2 | CPU clock selection applied |
| cpu_clk_in | input | 1 | Ungated CPU clock |
| cpu_clk_o | output | 1 | Gated CPU clock |
| pclk_in | input | 4 | Peripheral-source clocks f1, f8, f32, ADC |
| pclk_o | output | 4 | Gated peripheral-source clocks |
| div_clk_in | input | 1 | Programmable divider clock |
| div_src_main | input | 1 | 1 when the divider is fed by the main clock |
| div_clk_o | output | 1 | Gated divider clock |
| sub_clk | input | 1 | Low-speed sub-clock |
| clko_sel | input | 2 | Clock-output source select |
| clkout | output | 1 | Clock-output pin |
| port_in | input | 8 | Port output values from the core |
| port_out | output | 8 | Port outputs, held in wait |
| dac0_in | input | 8 | DAC 0 value |
| dac0_out | output | 8 | DAC 0 output, held in wait |
| dac1_in | input | 8 | DAC 1 value |
| dac1_out | output | 8 | DAC 1 output, held in wait |
| in_wait | output | 1 | High while in wait |
| resume_o | output | 1 | One-cycle resume pulse to the core |

## Verification
The hardest case to reach from the ports is a frozen clock: a gate that is stopped shows no event, so it has to be told apart from a slow clock that merely has not toggled yet. The bench lets the slowest divided clock settle for a few periods after wait entry. It then counts the rising edges of each gated output over a window longer than two sub-clock periods and expects zero edges with the output resting low. The wake conditions are reached with randomly chosen sparse request patterns, random levels that include 000, random gated-source flags and both stop-bit values. Directed single-line cases are added to isolate the disabled-level and gated-source exclusions.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_WAKE = 2'd2
  } lpw_state_t;

  localparam int LVL_W = 3;

  // request may end the wait: enabled level and not cut off by the stop bit
  function automatic logic irq_can_wake(input logic req, input logic [LVL_W-1:0] lvl,
                                        input logic gsrc, input logic stop);
    return req && (lvl != '0) && !(gsrc && stop);
  endfunction

  // peripheral-source clocks run unless waiting with the stop bit set
  function automatic logic psrc_runs(input lpw_state_t st, input logic stop);
    return !((st == ST_WAIT) && stop);
  endfunction
endpackage

// File: rtl/lpw_cgate.sv
module lpw_cgate (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);
  logic en_l;

  // enable may only change while the clock is low
  always_latch begin
    if (!clk_i) en_l = en_i;
  end

  assign clk_o = clk_i & en_l;
endmodule

// File: rtl/lpw_wake.sv
module lpw_wake #(
  parameter int N_IRQ = 64
) (
  input  logic                           nmi,
  input  logic                           stop,
  input  logic [N_IRQ-1:0]               irq_req,
  input  logic [N_IRQ*lpw_pkg::LVL_W-1:0] irq_lvl,
  input  logic [N_IRQ-1:0]               irq_gsrc,
  output logic                           irq_hit,
  output logic                           wake
);
  import lpw_pkg::*;

  logic [N_IRQ-1:0] elig;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    assign elig[i] = irq_can_wake(irq_req[i], irq_lvl[i*LVL_W +: LVL_W],
                                  irq_gsrc[i], stop);
  end

  assign irq_hit = |elig;
  assign wake    = irq_hit | nmi;
endmodule

// File: rtl/lpw_wait_ctrl.sv
module lpw_wait_ctrl #(
  parameter int N_IRQ   = 64,
  parameter int N_PCLK  = 4,
  parameter int PORT_W  = 8,
  parameter int DAC_W   = 8,
  parameter int SEL_W   = 2,
  parameter int F8_IDX  = 1,
  parameter int F32_IDX = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wait_stb,
  input  logic                            nmi,
  input  logic [N_IRQ-1:0]                irq_req,
  input  logic [N_IRQ*lpw_pkg::LVL_W-1:0] irq_lvl,
  input  logic [N_IRQ-1:0]                irq_gsrc,
  input  logic                            stop_wr,
  input  logic                            stop_d,
  input  logic [SEL_W-1:0]                cpu_sel_req,
  output logic [SEL_W-1:0]                cpu_sel_o,
  input  logic                            cpu_clk_in,
  output logic                            cpu_clk_o,
  input  logic [N_PCLK-1:0]               pclk_in,
  output logic [N_PCLK-1:0]               pclk_o,
  input  logic                            div_clk_in,
  input  logic                            div_src_main,
  output logic                            div_clk_o,
  input  logic                            sub_clk,
  input  logic [1:0]                      clko_sel,
  output logic                            clkout,
  input  logic [PORT_W-1:0]               port_in,
  output logic [PORT_W-1:0]               port_out,
  input  logic [DAC_W-1:0]                dac0_in,
  output logic [DAC_W-1:0]                dac0_out,
  input  logic [DAC_W-1:0]                dac1_in,
  output logic [DAC_W-1:0]                dac1_out,
  output logic                            in_wait,
  output logic                            resume_o
);
  import lpw_pkg::*;

  lpw_state_t state_q, state_d;
  logic       stop_q;
  logic       irq_hit, wake;
  logic       cpu_en, psrc_en, div_en;
  logic       hold_upd, sel_upd;

  lpw_wake #(.N_IRQ(N_IRQ)) u_wake (
    .nmi      (nmi),
    .stop     (stop_q),
    .irq_req  (irq_req),
    .irq_lvl  (irq_lvl),
    .irq_gsrc (irq_gsrc),
    .irq_hit  (irq_hit),
    .wake     (wake)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (wait_stb) state_d = ST_WAIT;
      ST_WAIT: if (wake)     state_d = ST_WAKE;
      ST_WAKE:               state_d = ST_RUN;
      default:               state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (stop_wr) stop_q <= stop_d;
    end
  end

  // held outputs and clock selection
  assign hold_upd = (state_q != ST_WAIT);
  assign sel_upd  = (state_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_out  <= '0;
      dac0_out  <= '0;
      dac1_out  <= '0;
      cpu_sel_o <= '0;
    end else begin
      if (hold_upd) begin
        port_out <= port_in;
        dac0_out <= dac0_in;
        dac1_out <= dac1_in;
      end
      if (sel_upd) cpu_sel_o <= cpu_sel_req;
    end
  end

  // gate enables
  assign cpu_en  = (state_q != ST_WAIT);
  assign psrc_en = psrc_runs(state_q, stop_q);
  assign div_en  = div_src_main | psrc_en;

  lpw_cgate u_cpu_gate (.clk_i(cpu_clk_in), .en_i(cpu_en), .clk_o(cpu_clk_o));
  lpw_cgate u_div_gate (.clk_i(div_clk_in), .en_i(div_en), .clk_o(div_clk_o));

  for (genvar p = 0; p < N_PCLK; p++) begin : g_pgate
    lpw_cgate u_gate (.clk_i(pclk_in[p]), .en_i(psrc_en), .clk_o(pclk_o[p]));
  end

  always_comb begin
    unique case (clko_sel)
      2'd0:    clkout = sub_clk;
      2'd1:    clkout = pclk_o[F8_IDX];
      2'd2:    clkout = pclk_o[F32_IDX];
      default: clkout = 1'b0;
    endcase
  end

  assign in_wait  = (state_q == ST_WAIT);
  assign resume_o = (state_q == ST_WAKE);
endmodule

// File: rtl/lpw_wait_chk.sv
module lpw_wait_chk #(
  parameter int PORT_W = 8,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_wait,
  input logic              resume_o,
  input logic              nmi,
  input logic              irq_hit,
  input logic              cpu_en,
  input logic [PORT_W-1:0] port_out,
  input logic [SEL_W-1:0]  cpu_sel_o
);
  // no eligible source: the wait persists
  assert_no_spurious_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !nmi && !irq_hit) |=> in_wait);

  // NMI always ends the wait
  assert_nmi_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && nmi) |=> (!in_wait && resume_o));

  // resume pulse lasts a single cycle and follows a wait
  assert_resume_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |=> !resume_o);
  assert_resume_after_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |-> ($past(in_wait) && cpu_en));

  // held values do not move during wait
  assert_port_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && $past(in_wait)) |-> $stable(port_out));
  assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_o || (in_wait && $past(in_wait))) |-> $stable(cpu_sel_o));
endmodule

bind lpw_wait_ctrl lpw_wait_chk #(.PORT_W(PORT_W), .SEL_W(SEL_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_wait   (in_wait),
  .resume_o  (resume_o),
  .nmi       (nmi),
  .irq_hit   (irq_hit),
  .cpu_en    (cpu_en),
  .port_out  (port_out),
  .cpu_sel_o (cpu_sel_o)
);

// File: tb/lpw_wait_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpw_wait_ctrl_tb_top;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_stb = 0, nmi = 0, stop_wr = 0, stop_d = 0, div_src_main = 0;
  logic [N-1:0] irq_req = '0, irq_gsrc = '0;
  logic [N*3-1:0] irq_lvl = '0;
  logic [1:0] cpu_sel_req = '0, clko_sel = '0;
  logic [1:0] cpu_sel_o;
  logic [7:0] port_in = '0, dac0_in = '0, dac1_in = '0;
  logic [7:0] port_out, dac0_out, dac1_out;
  logic cpu_clk_o, div_clk_o, clkout, in_wait, resume_o;
  logic [3:0] pclk_o, pclk_in;
  logic [7:0] cnt = '0;

  always #10 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 8'd1;
  assign pclk_in = {cnt[1], cnt[4], cnt[2], clk};

  lpw_wait_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wait_stb(wait_stb), .nmi(nmi),
    .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_gsrc(irq_gsrc),
    .stop_wr(stop_wr), .stop_d(stop_d),
    .cpu_sel_req(cpu_sel_req), .cpu_sel_o(cpu_sel_o),
    .cpu_clk_in(clk), .cpu_clk_o(cpu_clk_o),
    .pclk_in(pclk_in), .pclk_o(pclk_o),
    .div_clk_in(cnt[3]), .div_src_main(div_src_main), .div_clk_o(div_clk_o),
    .sub_clk(cnt[5]), .clko_sel(clko_sel), .clkout(clkout),
    .port_in(port_in), .port_out(port_out),
    .dac0_in(dac0_in), .dac0_out(dac0_out),
    .dac1_in(dac1_in), .dac1_out(dac1_out),
    .in_wait(in_wait), .resume_o(resume_o)
  );

  int e_cpu = 0, e_p0 = 0, e_p1 = 0, e_p2 = 0, e_p3 = 0, e_div = 0, e_co = 0;
  always @(posedge cpu_clk_o) e_cpu <= e_cpu + 1;
  always @(posedge pclk_o[0]) e_p0 <= e_p0 + 1;
  always @(posedge pclk_o[1]) e_p1 <= e_p1 + 1;
  always @(posedge pclk_o[2]) e_p2 <= e_p2 + 1;
  always @(posedge pclk_o[3]) e_p3 <= e_p3 + 1;
  always @(posedge div_clk_o) e_div <= e_div + 1;
  always @(posedge clkout)    e_co  <= e_co + 1;

  int checks = 0, errors = 0;
  bit stop_m = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_stop(input bit v);
    @(negedge clk); stop_wr = 1; stop_d = v;
    @(negedge clk); stop_wr = 0;
    stop_m = v;
  endtask

  task automatic enter_wait();
    @(negedge clk); wait_stb = 1;
    @(negedge clk); wait_stb = 0;
  endtask

  task automatic exit_nmi();
    nmi = 1;
    @(negedge clk); nmi = 0;
    @(negedge clk);
  endtask

  function automatic bit exp_wake(input bit stp);
    for (int i = 0; i < N; i++)
      if (irq_req[i] && irq_lvl[3*i +: 3] != 3'b000 && !(stp && irq_gsrc[i])) return 1;
    return 0;
  endfunction

  int s_cpu, s_p0, s_p1, s_p2, s_p3, s_div, s_co;
  task automatic win_start();
    s_cpu = e_cpu; s_p0 = e_p0; s_p1 = e_p1; s_p2 = e_p2;
    s_p3 = e_p3; s_div = e_div; s_co = e_co;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(in_wait == 0 && resume_o == 0, "R10 reset state", in_wait, 0);
    chk(port_out == 0 && cpu_sel_o == 0, "R10 reset outputs", port_out, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // stop = 0: peripheral clocks keep running
    port_in = 8'hA5; dac0_in = 8'h3C; dac1_in = 8'h81; cpu_sel_req = 2'd2;
    clko_sel = 2'd1; div_src_main = 0;
    set_stop(0);
    enter_wait();
    chk(in_wait == 1, "R1 wait entered", in_wait, 1);
    port_in = 8'h11; dac0_in = 8'h22; dac1_in = 8'h33; cpu_sel_req = 2'd1;
    repeat (40) @(negedge clk);
    win_start();
    repeat (140) @(negedge clk);
    chk(e_cpu == s_cpu, "R1 cpu clock stopped", e_cpu - s_cpu, 0);
    chk(cpu_clk_o == 0, "R1 cpu clock rests low", cpu_clk_o, 0);
    chk(e_p0 > s_p0 && e_p1 > s_p1 && e_p2 > s_p2 && e_p3 > s_p3,
        "R4 psrc clocks run stop=0", e_p2 - s_p2, 4);
    chk(e_div > s_div, "R4 div clock runs stop=0", e_div - s_div, 8);
    chk(e_co > s_co, "R9 clkout f8 runs stop=0", e_co - s_co, 17);
    chk(port_out == 8'hA5, "R8 port hold", port_out, 8'hA5);
    chk(dac0_out == 8'h3C && dac1_out == 8'h81, "R8 dac hold", dac0_out, 8'h3C);
    chk(cpu_sel_o == 2'd2, "R7 sel frozen", cpu_sel_o, 2);
    nmi = 1;
    @(negedge clk); nmi = 0;
    chk(in_wait == 0 && resume_o == 1, "R2 nmi wake", resume_o, 1);
    chk(cpu_sel_o == 2'd2, "R7 sel at resume", cpu_sel_o, 2);
    @(negedge clk);
    chk(resume_o == 0, "R11 one-cycle resume", resume_o, 0);

    // stop = 1: peripheral-source clocks frozen, main-fed divider runs
    set_stop(1);
    div_src_main = 1; clko_sel = 2'd2;
    enter_wait();
    repeat (40) @(negedge clk);
    win_start();
    repeat (140) @(negedge clk);
    chk(e_p0 == s_p0 && e_p1 == s_p1 && e_p2 == s_p2 && e_p3 == s_p3,
        "R4 psrc clocks stopped stop=1", e_p1 - s_p1, 0);
    chk(pclk_o == 4'b0000, "R4 psrc clocks rest low", pclk_o, 0);
    chk(e_div > s_div, "R6 main-fed div runs", e_div - s_div, 8);
    chk(e_co == s_co && clkout == 0, "R9 clkout f32 frozen low", e_co - s_co, 0);
    clko_sel = 2'd0;
    win_start();
    repeat (140) @(negedge clk);
    chk(e_co > s_co, "R9 clkout sub runs", e_co - s_co, 2);
    clko_sel = 2'd3;
    @(negedge clk);
    win_start();
    repeat (70) @(negedge clk);
    chk(e_co == s_co && clkout == 0, "R9 clkout sel3 low", clkout, 0);
    div_src_main = 0;
    win_start();
    repeat (40) @(negedge clk);
    chk(e_div == s_div, "R4 periph-fed div stopped", e_div - s_div, 0);
    exit_nmi();

    // directed: level 000 never wakes (R3)
    set_stop(0);
    enter_wait();
    irq_req[5] = 1; irq_lvl[15 +: 3] = 3'b000;
    repeat (3) @(negedge clk);
    chk(in_wait == 1 && resume_o == 0, "R3 level 000 ignored", in_wait, 1);
    irq_lvl[15 +: 3] = 3'b100;
    @(negedge clk);
    chk(in_wait == 0 && resume_o == 1, "R3 enabled level wakes", in_wait, 0);
    irq_req = '0; irq_lvl = '0;
    @(negedge clk);

    // directed: gated-source request ignored with stop = 1 (R5)
    set_stop(1);
    enter_wait();
    irq_req[40] = 1; irq_lvl[120 +: 3] = 3'b011; irq_gsrc[40] = 1;
    repeat (3) @(negedge clk);
    chk(in_wait == 1, "R5 gated source ignored", in_wait, 1);
    irq_gsrc[40] = 0;
    @(negedge clk);
    chk(in_wait == 0 && resume_o == 1, "R5 independent source wakes", in_wait, 0);
    irq_req = '0; irq_lvl = '0; irq_gsrc = '0;
    @(negedge clk);

    // random patterns (R3, R5)
    for (int it = 0; it < 60; it++) begin
      bit st, ew;
      st = bit'($urandom_range(0, 1));
      set_stop(st);
      enter_wait();
      for (int k = 0; k < 3; k++) begin
        int idx;
        idx = int'($urandom_range(0, N - 1));
        irq_req[idx] = 1;
        irq_lvl[3*idx +: 3] = 3'($urandom_range(0, 7));
        if ($urandom_range(0, 2) == 0) irq_lvl[3*idx +: 3] = 3'b000;
        irq_gsrc[idx] = bit'($urandom_range(0, 1));
      end
      ew = exp_wake(stop_m);
      @(negedge clk);
      chk(in_wait == !ew, "R3 R5 random wake decision", in_wait, int'(!ew));
      chk(resume_o == ew, "R11 random resume pulse", resume_o, int'(ew));
      irq_req = '0; irq_lvl = '0; irq_gsrc = '0;
      @(negedge clk);
      if (in_wait) exit_nmi();
    end

    // asynchronous reset during wait (R10)
    set_stop(1);
    enter_wait();
    #3 rst_n = 0;
    #2;
    chk(in_wait == 0 && resume_o == 0, "R10 async clear", in_wait, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(resume_o == 0, "R10 no resume after reset", resume_o, 0);
    stop_m = 0;
    enter_wait();
    repeat (40) @(negedge clk);
    win_start();
    repeat (140) @(negedge clk);
    chk(e_p2 > s_p2, "R10 stop bit back to 0", e_p2 - s_p2, 4);
    exit_nmi();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule